// File: doc/BRIEF.md
# Limit-Check Interrupt Controller

This block sits behind a hardware-monitoring converter and checks each newly stored result against programmable bounds. Results arrive as 8-bit words tagged with a channel index. Channel 0 is temperature, channels 1 to 7 are voltages and channels 8 to 10 are fan counts. A temperature or voltage result is out of bounds when it is strictly above its high bound or strictly below its low bound. A fan count is out of bounds only when it is strictly above its single bound. Every violation sets a sticky status bit. Two further sticky bits record the active-low board over-temperature input and the latched chassis-intrusion input.

The block drives two interrupt outputs as open-drain pads. Each output is an active-low output enable, and the pad data is tied to 0 outside the block. The management interrupt can also be pulled by an active-low chain input from another device. The second interrupt has two modes. In level-request mode it stays asserted while an unmasked event is pending. In non-maskable mode it gives a one-cycle pulse each time pending goes from clear to set. A register port holds the bounds, the masks, the configuration and the status. It also starts a timed pulse that clears the external intrusion latch.

Top module: `lim_irq_ctrl`

## Requirements
- R1: After reset the configuration reads 0x00, all three output enables are high (released), status reads 0, every high bound reads 0xFF and every low bound reads 0x00.
- R2: For channels 0 to 7, a sample sets status bit `chan` in the same clock edge when the value is strictly above the high bound (address 0x10+2*chan) or strictly below the low bound (address 0x11+2*chan). A value equal to either bound sets nothing.
- R3: For channels 8 to 10, a sample sets status bit `chan` (register 0x02, bit chan-8) only when the count is strictly above the bound at 0x10+2*chan. Low counts and equal counts set nothing.
- R4: Status bits are sticky. Reading 0x01 (channels 0 to 7) or 0x02 (bits 0 to 2 fans, bit 3 over-temperature, bit 4 intrusion) returns the bits and clears them, but an event that arrives in the same cycle as the read is kept.
- R5: `smiOeN` is low exactly when configuration bit 1 is 1 and a status bit is set whose mask bit is 0. The mask bits are at 0x03 for register 0x01 and at 0x04 for register 0x02.
- R6: `chainInN` low pulls `smiOeN` low when configuration bit 1 is 1 and mask bit 6 of 0x04 is 0.
- R7: With configuration bit 2 set and bit 5 clear, `irq2OeN` is low for as long as a status bit is set whose mask bit is 0. The mask bits are at 0x05 and 0x06. When bit 2 is clear, `irq2OeN` stays high.
- R8: With configuration bits 2 and 5 both set, `irq2OeN` is low for exactly one cycle after pending rises, and then stays high even though the status remains set.
- R9: A cycle with `btiN` low sets bit 3 of 0x02.
- R10: `intrIn` high sets bit 4 of 0x02. Writing 0x06 with bit 7 set drives `intrClrOeN` low for exactly CLR_CYCLES cycles starting at the write edge. Afterwards bit 7 of 0x06 reads 0.
- R11: A sample whose channel index is 11 or above changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a status read clears that register |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| smpValid | input | 1 | New result present |
| smpChan | input | 4 | Channel index of the result |
| smpData | input | 8 | Result value |
| chainInN | input | 1 | Chained management-interrupt request, active low |
| btiN | input | 1 | Board over-temperature, active low |
| intrIn | input | 1 | Chassis-intrusion latch state, active high |
| smiOeN | output | 1 | Management interrupt pad enable, active low |
| irq2OeN | output | 1 | Second interrupt pad enable, active low |
| intrClrOeN | output | 1 | Intrusion-latch clear pad enable, active low |

## Verification
A wrong comparator or a wrong bound register makes the status read that follows each sample differ in one bit, so a table of samples placed on and next to each bound finds it within two cycles. A stuck or wrongly cleared status bit shows on `smiOeN` or `irq2OeN` in the cycle after the sample edge, or on the status read that should have cleared it. A fault in the edge detect of the pulse mode shows as an output held low one cycle too long. A wrong clear counter shows as a pulse length different from CLR_CYCLES.

// File: rtl/lim_irq_pkg.sv
package lim_irq_pkg;
  localparam int DW       = 8;
  localparam int AW       = 8;
  localparam int NUM_VOLT = 7;
  localparam int NUM_FAN  = 3;
  localparam int NCH      = 1 + NUM_VOLT + NUM_FAN;
  localparam int FAN_BASE = 1 + NUM_VOLT;
  localparam int CHW      = $clog2(NCH + 1);
  localparam int NSTAT    = NCH + 2;
  localparam int ST_OT    = NCH;
  localparam int ST_INTR  = NCH + 1;
  localparam int NHI      = NSTAT - DW;

  localparam logic [AW-1:0] A_CFG = 8'h00;
  localparam logic [AW-1:0] A_STA = 8'h01;
  localparam logic [AW-1:0] A_STB = 8'h02;
  localparam logic [AW-1:0] A_SMA = 8'h03;
  localparam logic [AW-1:0] A_SMB = 8'h04;
  localparam logic [AW-1:0] A_NMA = 8'h05;
  localparam logic [AW-1:0] A_NMB = 8'h06;
  localparam logic [AW-1:0] A_LIM = 8'h10;

  typedef struct packed {
    logic           clrA;
    logic           clrB;
    logic           limWr;
    logic [CHW-1:0] limIdx;
    logic           limLow;
    logic [DW-1:0]  wrData;
  } strobe_t;
endpackage

// File: rtl/lim_irq_dp.sv
module lim_irq_dp
  import lim_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             smpValid,
  input  logic [CHW-1:0]   smpChan,
  input  logic [DW-1:0]    smpData,
  input  logic             btiN,
  input  logic             intrIn,
  input  logic [CHW-1:0]   rdIdx,
  input  logic             rdLow,
  output logic [DW-1:0]    limRdData,
  output logic [NSTAT-1:0] statusQ
);
  logic [DW-1:0]    hiVec [NCH];
  logic [DW-1:0]    loVec [NCH];
  logic [NSTAT-1:0] setVec;
  logic [NSTAT-1:0] clrMask;

  for (genvar ch = 0; ch < NCH; ch++) begin : gen_ch
    logic [DW-1:0] hiQ;
    logic          selHere;
    logic          outOfBounds;
    assign selHere = smpValid && (smpChan == CHW'(ch));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hiQ <= '1;
      else if (stb.limWr && !stb.limLow && stb.limIdx == CHW'(ch)) hiQ <= stb.wrData;
    end
    assign hiVec[ch] = hiQ;

    if (ch < FAN_BASE) begin : gen_window
      logic [DW-1:0] loQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) loQ <= '0;
        else if (stb.limWr && stb.limLow && stb.limIdx == CHW'(ch)) loQ <= stb.wrData;
      end
      assign loVec[ch]   = loQ;
      assign outOfBounds = (smpData > hiQ) || (smpData < loQ);
    end else begin : gen_fan
      assign loVec[ch]   = '0;
      assign outOfBounds = smpData > hiQ;
    end

    assign setVec[ch] = selHere && outOfBounds;
  end

  assign setVec[ST_OT]   = ~btiN;
  assign setVec[ST_INTR] = intrIn;

  always_comb begin
    for (int i = 0; i < NSTAT; i++) clrMask[i] = (i < DW) ? stb.clrA : stb.clrB;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | setVec;
  end

  always_comb begin
    limRdData = '0;
    if (rdIdx < CHW'(NCH)) limRdData = rdLow ? loVec[rdIdx] : hiVec[rdIdx];
  end
endmodule

// File: rtl/lim_irq_ctl.sv
module lim_irq_ctl
  import lim_irq_pkg::*;
#(
  parameter int CLR_CYCLES = 2000000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [AW-1:0]    regAddr,
  input  logic [DW-1:0]    regWrData,
  input  logic [NSTAT-1:0] statusQ,
  input  logic [DW-1:0]    limRdData,
  input  logic             chainInN,
  output strobe_t          stb,
  output logic [CHW-1:0]   rdIdx,
  output logic             rdLow,
  output logic [DW-1:0]    regRdData,
  output logic [DW-1:0]    cfgQ,
  output logic             smiOeN,
  output logic             irq2OeN,
  output logic             intrClrOeN
);
  localparam int CNT_W = $clog2(CLR_CYCLES + 1);

  logic [DW-1:0]    smiMaskA, smiMaskB, nmiMaskA;
  logic [DW-2:0]    nmiMaskB;
  logic [CNT_W-1:0] clrCnt;
  logic [AW-1:0]    limOff;
  logic             isLim, smiPend, nmiPend, nmiPendQ;
  logic [DW-1:0]    stA, stB;

  assign limOff = regAddr - A_LIM;
  assign isLim  = (regAddr >= A_LIM) && (limOff < AW'(2 * NCH));
  assign rdIdx  = CHW'(limOff >> 1);
  assign rdLow  = limOff[0];

  assign stb.clrA   = regRdEn && (regAddr == A_STA);
  assign stb.clrB   = regRdEn && (regAddr == A_STB);
  assign stb.limWr  = regWrEn && isLim;
  assign stb.limIdx = rdIdx;
  assign stb.limLow = rdLow;
  assign stb.wrData = regWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '0;
      smiMaskA <= '0;
      smiMaskB <= '0;
      nmiMaskA <= '0;
      nmiMaskB <= '0;
      clrCnt   <= '0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          A_CFG:   cfgQ     <= regWrData;
          A_SMA:   smiMaskA <= regWrData;
          A_SMB:   smiMaskB <= regWrData;
          A_NMA:   nmiMaskA <= regWrData;
          A_NMB:   nmiMaskB <= regWrData[DW-2:0];
          default: ;
        endcase
      end
      if (regWrEn && regAddr == A_NMB && regWrData[DW-1]) clrCnt <= CNT_W'(CLR_CYCLES);
      else if (clrCnt != '0)                             clrCnt <= clrCnt - 1'b1;
    end
  end

  assign stA = statusQ[DW-1:0];
  assign stB = {{(DW-NHI){1'b0}}, statusQ[NSTAT-1:DW]};

  assign smiPend = (|(stA & ~smiMaskA)) || (|(stB & ~smiMaskB)) || (!chainInN && !smiMaskB[6]);
  assign nmiPend = (|(stA & ~nmiMaskA)) || (|(stB & ~{1'b1, nmiMaskB}));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nmiPendQ <= 1'b0;
    else       nmiPendQ <= nmiPend;
  end

  assign smiOeN     = ~(cfgQ[1] && smiPend);
  assign irq2OeN    = ~(cfgQ[2] && (cfgQ[5] ? (nmiPend && !nmiPendQ) : nmiPend));
  assign intrClrOeN = (clrCnt == '0);

  always_comb begin
    regRdData = '0;
    if (isLim) regRdData = limRdData;
    else begin
      case (regAddr)
        A_CFG:   regRdData = cfgQ;
        A_STA:   regRdData = stA;
        A_STB:   regRdData = stB;
        A_SMA:   regRdData = smiMaskA;
        A_SMB:   regRdData = smiMaskB;
        A_NMA:   regRdData = nmiMaskA;
        A_NMB:   regRdData = {clrCnt != '0, nmiMaskB};
        default: regRdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/lim_irq_ctrl.sv
module lim_irq_ctrl
  import lim_irq_pkg::*;
#(
  parameter int CLR_CYCLES = 2000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [7:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        smpValid,
  input  logic [3:0]  smpChan,
  input  logic [7:0]  smpData,
  input  logic        chainInN,
  input  logic        btiN,
  input  logic        intrIn,
  output logic        smiOeN,
  output logic        irq2OeN,
  output logic        intrClrOeN
);
  strobe_t          stb;
  logic [NSTAT-1:0] statusQ;
  logic [DW-1:0]    limRdData;
  logic [DW-1:0]    cfgQ;
  logic [CHW-1:0]   rdIdx;
  logic             rdLow;

  lim_irq_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .smpValid(smpValid), .smpChan(smpChan), .smpData(smpData),
    .btiN(btiN), .intrIn(intrIn),
    .rdIdx(rdIdx), .rdLow(rdLow),
    .limRdData(limRdData), .statusQ(statusQ)
  );

  lim_irq_ctl #(.CLR_CYCLES(CLR_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .statusQ(statusQ), .limRdData(limRdData), .chainInN(chainInN),
    .stb(stb), .rdIdx(rdIdx), .rdLow(rdLow), .regRdData(regRdData), .cfgQ(cfgQ),
    .smiOeN(smiOeN), .irq2OeN(irq2OeN), .intrClrOeN(intrClrOeN)
  );
endmodule

// File: rtl/lim_irq_chk.sv
module lim_irq_chk
  import lim_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [DW-1:0]    cfgQ,
  input logic [NSTAT-1:0] statusQ,
  input strobe_t          stb,
  input logic             regWrEn,
  input logic [AW-1:0]    regAddr,
  input logic [DW-1:0]    regWrData,
  input logic             smiOeN,
  input logic             irq2OeN,
  input logic             intrClrOeN
);
  // R4
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clrA && !stb.clrB) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R5
  smi_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ[1] |-> smiOeN);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgQ[2] |-> irq2OeN);

  // R8
  nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[5] && !irq2OeN) |=> (irq2OeN || !cfgQ[5]));

  // R10
  intr_clr_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intrClrOeN) |-> $past(regWrEn && regAddr == A_NMB && regWrData[7]));
endmodule

bind lim_irq_ctrl lim_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgQ(cfgQ), .statusQ(statusQ), .stb(stb),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .smiOeN(smiOeN), .irq2OeN(irq2OeN), .intrClrOeN(intrClrOeN)
);

// File: tb/lim_irq_ctrl_tb_top.sv
module lim_irq_ctrl_tb_top;
  localparam int CLR = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regAddr = '0, regWrData = '0;
  logic [7:0] regRdData;
  logic       smpValid = 1'b0;
  logic [3:0] smpChan = '0;
  logic [7:0] smpData = '0;
  logic       chainInN = 1'b1, btiN = 1'b1, intrIn = 1'b0;
  logic       smiOeN, irq2OeN, intrClrOeN;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lim_irq_ctrl #(.CLR_CYCLES(CLR)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .smpValid(smpValid), .smpChan(smpChan), .smpData(smpData),
    .chainInN(chainInN), .btiN(btiN), .intrIn(intrIn),
    .smiOeN(smiOeN), .irq2OeN(irq2OeN), .intrClrOeN(intrClrOeN)
  );

  // {chan, data, expect set}: bounds ch0 0x20..0x50, ch3 0x64..0xC8, fan ch9 0x90
  localparam logic [12:0] VEC [12] = '{
    {4'd0, 8'h50, 1'b0}, {4'd0, 8'h51, 1'b1}, {4'd0, 8'h20, 1'b0}, {4'd0, 8'h1F, 1'b1},
    {4'd3, 8'hC9, 1'b1}, {4'd3, 8'h64, 1'b0}, {4'd3, 8'h80, 1'b0}, {4'd3, 8'h00, 1'b1},
    {4'd9, 8'h90, 1'b0}, {4'd9, 8'h91, 1'b1}, {4'd9, 8'h00, 1'b0}, {4'd12, 8'hFF, 1'b0}
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [7:0] d);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic sample(input logic [3:0] c, input logic [7:0] v);
    smpValid = 1'b1; smpChan = c; smpData = v;
    @(posedge clk); @(negedge clk);
    smpValid = 1'b0;
  endtask

  task automatic clearStatus();
    logic [7:0] dummy;
    rdReg(8'h01, dummy);
    rdReg(8'h02, dummy);
  endtask

  initial begin
    logic [7:0] a, b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdReg(8'h00, a); check("R1 cfg", a, 0);
    check("R1 outputs", {smiOeN, irq2OeN, intrClrOeN}, 3'b111);
    rdReg(8'h10, a); check("R1 high bound", a, 8'hFF);
    rdReg(8'h11, a); check("R1 low bound", a, 8'h00);
    rdReg(8'h01, a); check("R1 status", a, 0);

    wrReg(8'h10, 8'h50); wrReg(8'h11, 8'h20);
    wrReg(8'h16, 8'hC8); wrReg(8'h17, 8'h64);
    wrReg(8'h22, 8'h90);

    // R2 R3 R11 table
    for (int i = 0; i < 12; i++) begin
      logic [3:0] c;
      int expv;
      c = VEC[i][12:9];
      clearStatus();
      sample(c, VEC[i][8:1]);
      rdReg(8'h01, a); rdReg(8'h02, b);
      expv = VEC[i][0] ? (1 << c) : 0;
      check(c >= 4'd11 ? "R11 ignored channel" : (c >= 4'd8 ? "R3 fan compare" : "R2 window compare"),
            {b[4:0], a}, expv);
    end

    // R5 management output
    clearStatus();
    wrReg(8'h00, 8'h02);
    sample(4'd0, 8'h60);
    check("R5 smi asserted", smiOeN, 0);
    @(negedge clk); check("R4 sticky holds output", smiOeN, 0);
    wrReg(8'h03, 8'h01);
    check("R5 masked", smiOeN, 1);
    wrReg(8'h03, 8'h00);
    rdReg(8'h01, a);
    check("R4 read value", a, 8'h01);
    check("R4 read clears", smiOeN, 1);

    // R4 event during read
    regRdEn = 1'b1; regAddr = 8'h01; smpValid = 1'b1; smpChan = 4'd0; smpData = 8'h60;
    @(posedge clk); @(negedge clk);
    regRdEn = 1'b0; smpValid = 1'b0;
    rdReg(8'h01, a);
    check("R4 set wins over clear", a, 8'h01);

    // R6 chain input
    chainInN = 1'b0; #1;
    check("R6 chain passes", smiOeN, 0);
    wrReg(8'h04, 8'h40);
    check("R6 chain masked", smiOeN, 1);
    chainInN = 1'b1;
    wrReg(8'h04, 8'h00);

    // R7 level mode
    wrReg(8'h00, 8'h04);
    sample(4'd0, 8'h60);
    check("R7 level asserted", irq2OeN, 0);
    check("R5 smi off when disabled", smiOeN, 1);
    @(negedge clk); @(negedge clk);
    check("R7 level held", irq2OeN, 0);
    clearStatus();
    wrReg(8'h05, 8'h01);
    sample(4'd0, 8'h60);
    check("R7 masked", irq2OeN, 1);
    clearStatus();
    wrReg(8'h05, 8'h00);

    // R8 pulse mode
    wrReg(8'h00, 8'h24);
    sample(4'd0, 8'h60);
    check("R8 pulse low", irq2OeN, 0);
    @(negedge clk);
    check("R8 pulse ends", irq2OeN, 1);
    clearStatus();
    wrReg(8'h00, 8'h00);

    // R9 over-temperature
    btiN = 1'b0; @(posedge clk); @(negedge clk); btiN = 1'b1;
    rdReg(8'h02, a); check("R9 over-temp bit", a, 8'h08);
    rdReg(8'h02, a); check("R9 cleared", a, 8'h00);

    // R10 intrusion and clear pulse
    intrIn = 1'b1; @(posedge clk); @(negedge clk); intrIn = 1'b0;
    rdReg(8'h02, a); check("R10 intrusion bit", a, 8'h10);
    wrReg(8'h06, 8'h80);
    begin
      int lows = 0;
      while (intrClrOeN == 1'b0 && lows < 100) begin
        lows++;
        @(negedge clk);
      end
      check("R10 clear pulse length", lows, CLR);
    end
    rdReg(8'h06, a); check("R10 bit7 after pulse", a, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule